// File: doc/BRIEF.md
# Supply and Manual Reset Supervisor

This block produces the system reset for a synchronous domain. It watches a digitized supply-good flag and a shared reset pin that works both as an output and as a manual reset input. While the supply is not good, reset is held. Once the supply has been good for long enough, reset stays asserted for a fixed release delay and then lets go. A falling edge on the shared pin, made by something outside, starts a fresh full-length reset pulse. A short external press is therefore stretched to the whole delay. A long press does not make the pulse longer.

The pin is modelled as a drive-low enable and a sampled pin level. When the enable is off, an external pull sets the level. Both inputs go through persistence filters, so brief dips are rejected. The falling-edge detector is blanked while the block drives the pin itself, so the block's own drive cannot retrigger it. All durations are parameters counted in clock cycles. The inputs are assumed to be synchronous to `clk` already.

Top module: `rsv_supervisor`

## Requirements
- R1: While the filtered supply flag is low, `rst_o` is 1 on every cycle.
- R2: `supply_ok_i` rises and then stays high. Counting from the first clock edge that samples it high, `rst_o` is still 1 after edge SUP_HOLD+TIMEOUT-1 and is 0 after edge SUP_HOLD+TIMEOUT.
- R3: `pin_drive_o` is 1 exactly when `rst_o` is 1. When the delay ends, the drive is released (enable 0) rather than driving a high level.
- R4: The pin level goes from 1 to 0 and is held low for PIN_HOLD or more cycles while the block is not resetting. This starts a new reset pulse that lasts exactly TIMEOUT cycles.
- R5: The manual pulse length does not depend on the press length. A press shorter than TIMEOUT and a press longer than TIMEOUT both give a TIMEOUT-cycle pulse. A pin still held low when the pulse ends does not restart it.
- R6: A low level on the pin that lasts fewer than PIN_HOLD cycles causes no reset.
- R7: A low level on `supply_ok_i` that lasts fewer than SUP_HOLD cycles causes no reset.
- R8: The low level the block itself drives on the pin never triggers another pulse. Exactly one pulse results per external press.
- R9: `rst_n_o` is the complement of `rst_o` on every cycle.
- R10: While `rst_n` is low, and on the first cycle after it is released, `rst_o` is 1. The supply filter restarts as "not good", so the full supply path of R2 applies again.
- R11: A supply loss during a reset pulse keeps reset asserted. The release delay is counted again in full after the supply recovers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low logic reset |
| supply_ok_i | input | 1 | Digitized supply-above-threshold flag, 1 = good |
| pin_i | input | 1 | Sampled level of the shared reset pin |
| pin_drive_o | output | 1 | 1 = pull the shared pin low, 0 = release it to the external pull |
| rst_n_o | output | 1 | Active-low system reset |
| rst_o | output | 1 | Active-high system reset |

## Verification
The bench aims at the filter boundaries. It applies dips one cycle shorter than the hold counts, which must leave reset off, and presses just long enough to be accepted. A filter that is off by one would fire on the short dip or miss the accepted press. The bench checks the exact release cycle after power-up and the pulse length for short and long presses. A design that followed the pin level instead of its edge would give a long pulse for a long press, or a second pulse on release. The bench also drops the supply in the middle of a pulse and applies a logic reset during normal operation. A timer that was not restarted would then release early.

// File: rtl/rsv_pkg.sv
// Package: shared helpers for the reset supervisor.
// Assumes: used only at elaboration time.
package rsv_pkg;

    // Counter width able to hold values 0 .. n-1 (at least one bit).
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rsv_level_filter.sv
// Persistence filter: the output follows the raw input only after the raw
// input has differed from it on HOLD consecutive clock edges.
// Assumes: raw_i is synchronous to clk; HOLD >= 1.
module rsv_level_filter #(
    parameter int unsigned HOLD = 4,
    parameter bit          INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic lvl_o
);
    import rsv_pkg::*;

    localparam int unsigned CW = cnt_width(HOLD);
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    logic [CW-1:0] run_q;
    logic          lvl_q;

    // Count how long the raw level has disagreed; accept it at HOLD.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            lvl_q <= INIT;
        end else if (raw_i == lvl_q) begin
            run_q <= '0;
        end else if (run_q == LAST) begin
            run_q <= '0;
            lvl_q <= raw_i;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign lvl_o = lvl_q;
endmodule

// File: rtl/rsv_fall_detect.sv
// Falling-edge detector on a filtered pin level, blanked by a mask.
// Assumes: lvl_i is already filtered; the idle pin level is high.
module rsv_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic mask_i,
    output logic fall_o
);
    logic prev_q;

    // Remember the previous filtered level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= lvl_i;
    end

    // A high-to-low step counts only while the block is not driving the pin.
    always_comb fall_o = prev_q & ~lvl_i & ~mask_i;
endmodule

// File: rtl/rsv_hold_timer.sv
// Reset state and release-delay counter.
// Assumes: sup_ok_i and trig_i are synchronous; TIMEOUT >= 2.
module rsv_hold_timer #(
    parameter int unsigned TIMEOUT = 20
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  sup_ok_i,
    input  logic                                  trig_i,
    output logic                                  busy_o,
    output logic [rsv_pkg::cnt_width(TIMEOUT)-1:0] tmr_o
);
    import rsv_pkg::*;

    localparam int unsigned   TW   = cnt_width(TIMEOUT);
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT - 1);

    logic          busy_q;
    logic [TW-1:0] tmr_q;

    // Hold while supply is bad, restart on a trigger, otherwise count to release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b1;
            tmr_q  <= '0;
        end else if (!sup_ok_i || trig_i) begin
            busy_q <= 1'b1;
            tmr_q  <= '0;
        end else if (busy_q) begin
            if (tmr_q == LAST) begin
                busy_q <= 1'b0;
                tmr_q  <= '0;
            end else begin
                tmr_q <= tmr_q + 1'b1;
            end
        end
    end

    assign busy_o = busy_q;
    assign tmr_o  = tmr_q;
endmodule

// File: rtl/rsv_supervisor.sv
// Top level of the reset supervisor: filters the supply flag and the
// shared pin, detects external presses and times the reset pulse.
// Assumes: inputs are synchronous to clk; TIMEOUT > PIN_HOLD + 1 so the
// pin filter settles while the block still drives the pin.
module rsv_supervisor #(
    parameter int unsigned SUP_HOLD = 16,
    parameter int unsigned PIN_HOLD = 10,
    parameter int unsigned TIMEOUT  = 20_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic pin_i,
    output logic pin_drive_o,
    output logic rst_n_o,
    output logic rst_o
);
    import rsv_pkg::*;

    localparam int unsigned TW = cnt_width(TIMEOUT);

    logic          sup_ok;
    logic          pin_lvl;
    logic          man_fall;
    logic          busy;
    logic [TW-1:0] tmr_q;

    rsv_level_filter #(.HOLD(SUP_HOLD), .INIT(1'b0)) u_sup_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (supply_ok_i),
        .lvl_o (sup_ok)
    );

    rsv_level_filter #(.HOLD(PIN_HOLD), .INIT(1'b1)) u_pin_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (pin_i),
        .lvl_o (pin_lvl)
    );

    rsv_fall_detect u_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (pin_lvl),
        .mask_i (busy),
        .fall_o (man_fall)
    );

    rsv_hold_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .sup_ok_i (sup_ok),
        .trig_i   (man_fall),
        .busy_o   (busy),
        .tmr_o    (tmr_q)
    );

    // All outputs come from the single registered reset state.
    always_comb begin
        pin_drive_o = busy;
        rst_o       = busy;
        rst_n_o     = ~busy;
    end
endmodule

// File: rtl/rsv_supervisor_chk.sv
// Checker for rsv_supervisor, bound to every instance of it.
// Assumes: connected to the top's internal filter, edge and timer signals.
module rsv_supervisor_chk #(
    parameter int unsigned TW      = 5,
    parameter int unsigned TIMEOUT = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sup_ok,
    input logic          man_fall,
    input logic          pin_drive_o,
    input logic          rst_n_o,
    input logic          rst_o,
    input logic [TW-1:0] tmr_q
);
    assert_supply_low_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_ok |=> rst_o);

    assert_release_after_full_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_o) |-> ($past(tmr_q) == TW'(TIMEOUT - 1)) && $past(sup_ok));

    assert_drive_tracks_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pin_drive_o == rst_o);

    assert_press_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        man_fall |=> rst_o && (tmr_q == '0));

    assert_no_self_trigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pin_drive_o |-> !man_fall);

    assert_polarity_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n_o != rst_o);

    assert_starts_asserted_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> rst_o && (tmr_q == '0));

    assert_timer_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q <= TW'(TIMEOUT - 1));
endmodule

bind rsv_supervisor rsv_supervisor_chk #(.TW(TW), .TIMEOUT(TIMEOUT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sup_ok      (sup_ok),
    .man_fall    (man_fall),
    .pin_drive_o (pin_drive_o),
    .rst_n_o     (rst_n_o),
    .rst_o       (rst_o),
    .tmr_q       (tmr_q)
);

// File: tb/tb_rsv_supervisor.sv
module tb_rsv_supervisor;
    localparam int SUP_HOLD = 4;
    localparam int PIN_HOLD = 3;
    localparam int TIMEOUT  = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic ext_low = 1'b0;
    logic pin_drive_o, rst_n_o, rst_o;
    logic pin_w;

    always #5 clk = ~clk;

    // Open-drain pin: low if anyone pulls it, else the pull-up wins.
    assign pin_w = (ext_low || pin_drive_o) ? 1'b0 : 1'b1;

    rsv_supervisor #(.SUP_HOLD(SUP_HOLD), .PIN_HOLD(PIN_HOLD), .TIMEOUT(TIMEOUT)) dut (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .pin_i(pin_w),
        .pin_drive_o(pin_drive_o), .rst_n_o(rst_n_o), .rst_o(rst_o)
    );

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    string cur_req = "R10";

    // Behavioural reference: accepted levels, disagreement runs, reset state.
    int m_sup, m_sup_run, m_pin, m_pin_run, m_pin_prev, m_busy, m_tmr;
    int p_raw, trig;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sup = 0; m_sup_run = 0; m_pin = 1; m_pin_run = 0;
            m_pin_prev = 1; m_busy = 1; m_tmr = 0;
        end else begin
            p_raw = (ext_low || m_busy != 0) ? 0 : 1;
            trig  = (m_pin_prev == 1 && m_pin == 0 && m_busy == 0) ? 1 : 0;
            if (m_sup == 0 || trig == 1) begin
                m_busy = 1; m_tmr = 0;
            end else if (m_busy == 1) begin
                if (m_tmr == TIMEOUT - 1) begin m_busy = 0; m_tmr = 0; end
                else m_tmr = m_tmr + 1;
            end
            m_pin_prev = m_pin;
            if (int'(supply_ok) == m_sup) m_sup_run = 0;
            else if (m_sup_run == SUP_HOLD - 1) begin m_sup = int'(supply_ok); m_sup_run = 0; end
            else m_sup_run = m_sup_run + 1;
            if (p_raw == m_pin) m_pin_run = 0;
            else if (m_pin_run == PIN_HOLD - 1) begin m_pin = p_raw; m_pin_run = 0; end
            else m_pin_run = m_pin_run + 1;
        end
    end

    // Pulse monitors, read by the explicit checks.
    int cur_len = 0, last_len = 0, pulses = 0;
    bit seen_high = 1'b0;
    logic prev_rst = 1'b1;

    task automatic check(input string req, input int act, input int exp_v);
        compared++;
        if (act != exp_v) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp_v, $time);
        end
    endtask

    // Per-cycle comparison with the model, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            check(cur_req, int'(rst_o), m_busy);
            check("R3", int'(pin_drive_o), m_busy);
            check("R9", int'(rst_n_o), 1 - int'(rst_o));
            if (rst_o) begin
                cur_len++;
                seen_high = 1'b1;
                if (!prev_rst) pulses++;
            end else if (prev_rst) begin
                last_len = cur_len;
                cur_len = 0;
            end else begin
                cur_len = 0;
            end
            prev_rst = rst_o;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        #1_000_000;
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        // R10: logic reset gives asserted outputs.
        cycles(3);
        check("R10", int'(rst_o), 1);
        @(negedge clk); rst_n = 1'b1;
        cycles(1);
        check("R10", int'(rst_o), 1);
        // R1: supply low keeps reset.
        cur_req = "R1";
        cycles(20);
        check("R1", int'(rst_o), 1);

        // R2: exact release after supply becomes good.
        cur_req = "R2";
        @(negedge clk); supply_ok = 1'b1;
        cycles(SUP_HOLD + TIMEOUT - 1);
        check("R2", int'(rst_o), 1);
        cycles(1);
        check("R2", int'(rst_o), 0);
        check("R3", int'(pin_drive_o), 0);
        cycles(10);

        // R7: short supply dip is ignored.
        cur_req = "R7";
        seen_high = 1'b0;
        @(negedge clk); supply_ok = 1'b0;
        repeat (SUP_HOLD - 1) @(negedge clk);
        supply_ok = 1'b1;
        cycles(60);
        check("R7", int'(seen_high), 0);

        // R6: short pin glitch is ignored.
        cur_req = "R6";
        seen_high = 1'b0;
        @(negedge clk); ext_low = 1'b1;
        repeat (PIN_HOLD - 1) @(negedge clk);
        ext_low = 1'b0;
        cycles(60);
        check("R6", int'(seen_high), 0);

        // R4/R5/R8: short press is stretched to one full pulse.
        cur_req = "R4";
        pulses = 0;
        @(negedge clk); ext_low = 1'b1;
        repeat (PIN_HOLD + 2) @(negedge clk);
        ext_low = 1'b0;
        cycles(TIMEOUT + 40);
        check("R5", last_len, TIMEOUT);
        check("R8", pulses, 1);

        // R5: long press still gives one TIMEOUT pulse, no retrigger on release.
        cur_req = "R5";
        pulses = 0;
        @(negedge clk); ext_low = 1'b1;
        repeat (TIMEOUT + 30) @(negedge clk);
        #1;
        check("R5", int'(rst_o), 0);
        @(negedge clk); ext_low = 1'b0;
        cycles(60);
        check("R5", pulses, 1);
        check("R5", last_len, TIMEOUT);

        // R4: a fresh press after release starts a new pulse.
        cur_req = "R4";
        pulses = 0;
        @(negedge clk); ext_low = 1'b1;
        repeat (PIN_HOLD + 1) @(negedge clk);
        ext_low = 1'b0;
        cycles(TIMEOUT + 30);
        check("R4", pulses, 1);
        check("R4", last_len, TIMEOUT);

        // R11: supply loss inside a pulse restarts the full delay.
        cur_req = "R11";
        pulses = 0;
        @(negedge clk); ext_low = 1'b1;
        repeat (PIN_HOLD + 1) @(negedge clk);
        ext_low = 1'b0;
        repeat (10) @(negedge clk);
        supply_ok = 1'b0;
        repeat (20) @(negedge clk);
        supply_ok = 1'b1;
        cycles(TIMEOUT + 60);
        check("R11", pulses, 1);
        check("R11", (last_len > TIMEOUT + 20) ? 1 : 0, 1);

        // R10: logic reset during normal operation reasserts and restarts.
        cur_req = "R10";
        @(negedge clk); rst_n = 1'b0;
        cycles(2);
        check("R10", int'(rst_o), 1);
        @(negedge clk); rst_n = 1'b1;
        cycles(SUP_HOLD + TIMEOUT - 1);
        check("R10", int'(rst_o), 1);
        cycles(1);
        check("R10", int'(rst_o), 0);
        cycles(5);
        finish_run();
    end
endmodule